// File: doc/BRIEF.md
# Weighted Phase-Table Port Arbiter

This block decides which of four ingress ports may send the next packet toward a single egress virtual channel. Each cycle it looks at the per-port request lines and, if the channel is enabled and at least one port is asking, registers a one-hot grant together with a grant-valid strobe. Two schemes are available. Plain round-robin rotates priority among the requesting ports. Weighted round-robin walks a 128-slot phase table in which every slot names the port that owns it, so bandwidth shares follow how often each port appears in the table.

Software programs the table indirectly. Entries go into a shadow copy through a small address/data/write-enable port, and nothing the arbiter uses changes until a load command is written to the control register. The load copies the whole shadow table into the active table in one step and restarts the phase walk at slot 0. A read-only capability word reports which schemes exist, and the control word holds the scheme code, the load command and the channel enable.

Top module: `wrr_port_arb`

## Requirements
- R1: A grant appears on `gnt` one clock after the request it answers. `gnt` is one-hot or zero, `gntValid` is high exactly when `gnt` is nonzero, the granted port was requesting in the previous cycle, and with no port requesting no grant is issued.
- R2: In round-robin mode the search starts at the port after the last granted port and wraps from port 3 to port 0. Coming out of reset it acts as if port 3 was granted last. The last granted port is tracked through grants of both schemes.
- R3: Control word (`cfgSel`=1) bits [2:0] select the scheme: 000 is round-robin, 011 is weighted. Any other written value is stored and read back as 000 and behaves as round-robin. Reset value is 000.
- R4: With `cfgSel`=0 the read data is the capability word 0x00000009 (bit 0 round-robin, bit 3 weighted); writes with `cfgSel`=0 change nothing.
- R5: Control bit 7 enables the channel and resets to 1. While it is 0 no grant is issued whatever the requests.
- R6: In weighted mode the port granted is the one named by the first slot, counting upward from the phase pointer, whose port is requesting. The pointer then moves to the slot after the granted one and wraps from 127 to 0. The pointer resets to 0.
- R7: In weighted mode slots whose port is not requesting are skipped within the same cycle. If no slot names a requesting port, no grant is issued and the pointer keeps its value.
- R8: Writing `tblWrData` (a 2-bit port index) to slot `tblWrAddr` through `tblWrEn` changes only the shadow table; arbitration keeps using the active table. Both tables reset to slot i holding port i mod 4.
- R9: Writing 1 to control bit 4 copies the shadow table into the active table at the end of the following cycle and sets the phase pointer to 0. Any grant decided in that cycle still uses the old table. Bit 4 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSel | input | 1 | Register select: 0 capability word, 1 control word |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Read data of the selected register |
| tblWrEn | input | 1 | Shadow table write strobe |
| tblWrAddr | input | 7 | Shadow table slot index |
| tblWrData | input | 2 | Port index written into the slot |
| req | input | 4 | Per-port request lines |
| gnt | output | 4 | Registered one-hot grant |
| gntValid | output | 1 | High in the cycle a grant is presented |

## Verification
The bench reprograms the shadow table while grants keep flowing and checks that the old pattern continues; a design that wrote straight through would change its grant order early. It runs more than 128 weighted grants so the pointer must wrap from 127 to 0, and it drops the only port of most slots so skipped slots must be passed over in one cycle, or the arbiter would stall or grant a silent port. It also asks for a port that no slot names, which must yield no grant and leave the pointer where it was. It writes an illegal scheme code, which must fall back to round-robin rather than pick weighted mode, and it clears the enable, after which any grant is an error.

// File: rtl/wrr_port_arb_pkg.sv
`timescale 1ns/1ps
package wrr_port_arb_pkg;

  // Strobes the control block hands to the datapath every cycle.
  typedef struct packed {
    logic loadTbl;  // one-cycle pulse: copy shadow table into active table
    logic wrrMode;  // 1 = phase-table weighted scheme, 0 = round-robin
    logic chanEn;   // channel enable
  } arbCtrl_t;

  localparam logic [2:0] SCHEME_RR  = 3'b000;
  localparam logic [2:0] SCHEME_WRR = 3'b011;

  localparam int CTRL_LOAD_BIT = 4;
  localparam int CTRL_EN_BIT   = 7;

  localparam logic [7:0] CAP_VALUE = 8'h09;

endpackage

// File: rtl/wrr_port_arb_ctrl.sv
`timescale 1ns/1ps
module wrr_port_arb_ctrl
  import wrr_port_arb_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSel,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output arbCtrl_t         arbCtrl
);

  logic [2:0] schemeQ;
  logic       chanEnQ;
  logic       loadQ;
  logic       ctrlWrite;
  logic       unusedWrBits;

  assign ctrlWrite    = cfgWrEn && cfgSel;
  assign unusedWrBits = ^{cfgWrData[CFG_W-1:8], cfgWrData[6:5], cfgWrData[3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      schemeQ <= SCHEME_RR;
      chanEnQ <= 1'b1;
      loadQ   <= 1'b0;
    end else begin
      loadQ <= 1'b0;
      if (ctrlWrite) begin
        // only the weighted code is kept; everything else falls back
        schemeQ <= (cfgWrData[2:0] == SCHEME_WRR) ? SCHEME_WRR : SCHEME_RR;
        chanEnQ <= cfgWrData[CTRL_EN_BIT];
        loadQ   <= cfgWrData[CTRL_LOAD_BIT];
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgSel) begin
      cfgRdData[2:0]         = schemeQ;
      cfgRdData[CTRL_EN_BIT] = chanEnQ;
    end else begin
      cfgRdData[7:0] = CAP_VALUE;
    end
  end

  assign arbCtrl.loadTbl = loadQ;
  assign arbCtrl.wrrMode = (schemeQ == SCHEME_WRR);
  assign arbCtrl.chanEn  = chanEnQ;

endmodule

// File: rtl/wrr_port_arb_dp.sv
`timescale 1ns/1ps
module wrr_port_arb_dp
  import wrr_port_arb_pkg::*;
#(
  parameter  int NUM_PORTS  = 4,
  parameter  int NUM_PHASES = 128,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int PHASE_W    = $clog2(NUM_PHASES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbCtrl_t             arbCtrl,
  input  logic                 tblWrEn,
  input  logic [PHASE_W-1:0]   tblWrAddr,
  input  logic [PORT_W-1:0]    tblWrData,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt,
  output logic                 gntValid
);

  localparam logic [NUM_PORTS-1:0] GNT_ONE = {{(NUM_PORTS-1){1'b0}}, 1'b1};

  logic [PORT_W-1:0]     shadowTbl [NUM_PHASES];
  logic [PORT_W-1:0]     activeTbl [NUM_PHASES];
  logic [NUM_PHASES-1:0] phaseHit;
  logic [PHASE_W-1:0]    phasePtr;
  logic [PORT_W-1:0]     lastPort;

  logic                  rrFound;
  logic [PORT_W-1:0]     rrPick;
  logic                  wFound;
  logic [PHASE_W-1:0]    wPhase;
  logic [PORT_W-1:0]     wPort;
  logic                  grantNow;
  logic [PORT_W-1:0]     pickPort;

  // Table storage: shadow takes software writes, active follows on load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHASES; i++) begin
        shadowTbl[i] <= PORT_W'(i % NUM_PORTS);
        activeTbl[i] <= PORT_W'(i % NUM_PORTS);
      end
    end else begin
      if (tblWrEn) shadowTbl[tblWrAddr] <= tblWrData;
      if (arbCtrl.loadTbl) activeTbl <= shadowTbl;
    end
  end

  // A slot is eligible when the port it names is requesting.
  generate
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_hit
      assign phaseHit[i] = req[activeTbl[i]];
    end
  endgenerate

  // Round-robin: first requester after the last granted port.
  always_comb begin
    logic [PORT_W-1:0] idx;
    rrFound = 1'b0;
    rrPick  = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      idx = lastPort + PORT_W'(k);
      if (!rrFound && req[idx]) begin
        rrFound = 1'b1;
        rrPick  = idx;
      end
    end
  end

  // Weighted: first eligible slot from the phase pointer upward.
  always_comb begin
    logic [PHASE_W-1:0] ph;
    wFound = 1'b0;
    wPhase = '0;
    for (int k = 0; k < NUM_PHASES; k++) begin
      ph = phasePtr + PHASE_W'(k);
      if (!wFound && phaseHit[ph]) begin
        wFound = 1'b1;
        wPhase = ph;
      end
    end
  end

  assign wPort    = activeTbl[wPhase];
  assign pickPort = arbCtrl.wrrMode ? wPort : rrPick;
  assign grantNow = arbCtrl.chanEn && (arbCtrl.wrrMode ? wFound : rrFound);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gnt      <= '0;
      gntValid <= 1'b0;
      lastPort <= PORT_W'(NUM_PORTS - 1);
      phasePtr <= '0;
    end else begin
      gntValid <= grantNow;
      gnt      <= grantNow ? (GNT_ONE << pickPort) : '0;
      if (grantNow) lastPort <= pickPort;
      if (arbCtrl.loadTbl) begin
        phasePtr <= '0;
      end else if (grantNow && arbCtrl.wrrMode) begin
        phasePtr <= wPhase + PHASE_W'(1);
      end
    end
  end

endmodule

// File: rtl/wrr_port_arb.sv
`timescale 1ns/1ps
module wrr_port_arb
  import wrr_port_arb_pkg::*;
#(
  parameter  int NUM_PORTS  = 4,
  parameter  int NUM_PHASES = 128,
  parameter  int CFG_W      = 32,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int PHASE_W    = $clog2(NUM_PHASES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgSel,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  output logic [CFG_W-1:0]     cfgRdData,
  input  logic                 tblWrEn,
  input  logic [PHASE_W-1:0]   tblWrAddr,
  input  logic [PORT_W-1:0]    tblWrData,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt,
  output logic                 gntValid
);

  arbCtrl_t arbCtrl;

  wrr_port_arb_ctrl #(
    .CFG_W(CFG_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSel   (cfgSel),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .arbCtrl  (arbCtrl)
  );

  wrr_port_arb_dp #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_PHASES(NUM_PHASES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .arbCtrl  (arbCtrl),
    .tblWrEn  (tblWrEn),
    .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData),
    .req      (req),
    .gnt      (gnt),
    .gntValid (gntValid)
  );

endmodule

// File: rtl/wrr_port_arb_chk.sv
`timescale 1ns/1ps
module wrr_port_arb_chk
  import wrr_port_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CFG_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgSel,
  input logic [CFG_W-1:0]     cfgRdData,
  input logic [NUM_PORTS-1:0] req,
  input logic [NUM_PORTS-1:0] gnt,
  input logic                 gntValid,
  input arbCtrl_t             arbCtrl
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt) && (gntValid == (gnt != '0)));

  p_req_backed_r1: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> (($past(req) & gnt) != '0));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(req) == '0) |-> !gntValid);

  p_rr_rotate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid && $past(gntValid) && !$past(arbCtrl.wrrMode) && ($past(req) == '1))
    |-> (gnt == {$past(gnt[NUM_PORTS-2:0]), $past(gnt[NUM_PORTS-1])}));

  p_scheme_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |-> ((cfgRdData[2:0] == SCHEME_RR) || (cfgRdData[2:0] == SCHEME_WRR)));

  p_cap_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSel |-> (cfgRdData == CFG_W'(CAP_VALUE)));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(arbCtrl.chanEn) |-> !gntValid);

  p_load_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |-> !cfgRdData[CTRL_LOAD_BIT]);

endmodule

bind wrr_port_arb wrr_port_arb_chk #(
  .NUM_PORTS(NUM_PORTS),
  .CFG_W    (CFG_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgSel   (cfgSel),
  .cfgRdData(cfgRdData),
  .req      (req),
  .gnt      (gnt),
  .gntValid (gntValid),
  .arbCtrl  (arbCtrl)
);

// File: tb/wrr_port_arb_tb.sv
`timescale 1ns/1ps
module wrr_port_arb_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSel = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        tblWrEn = 1'b0;
  logic [6:0]  tblWrAddr = '0;
  logic [1:0]  tblWrData = '0;
  logic [3:0]  req = '0;
  logic [3:0]  gnt;
  logic        gntValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state, derived from the requirements
  logic [1:0] mTbl [128];
  logic [1:0] mShadow [128];
  int mPtr  = 0;
  int mLast = 3;
  bit mWrr  = 1'b0;
  bit mEn   = 1'b1;

  // {req, gnt, gntValid} for the round-robin walk after reset
  localparam logic [8:0] RR_VEC [10] = '{
    9'b1111_0001_1, 9'b1111_0010_1, 9'b1111_0100_1, 9'b1001_1000_1,
    9'b1001_0001_1, 9'b0000_0000_0, 9'b0110_0010_1, 9'b0100_0100_1,
    9'b0011_0001_1, 9'b1000_1000_1
  };

  wrr_port_arb u_dut (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .tblWrEn(tblWrEn),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData), .req(req),
    .gnt(gnt), .gntValid(gntValid)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic modelStep(input logic [3:0] r, output logic [3:0] eg, output logic ev);
    int pick;
    int ph;
    eg = '0;
    ev = 1'b0;
    pick = 0;
    ph = 0;
    if (mEn) begin
      if (mWrr) begin
        for (int k = 0; k < 128; k++) begin
          if (!ev && r[mTbl[(mPtr + k) % 128]]) begin
            ev = 1'b1;
            ph = (mPtr + k) % 128;
            pick = int'(mTbl[ph]);
          end
        end
        if (ev) mPtr = (ph + 1) % 128;
      end else begin
        for (int k = 1; k <= 4; k++) begin
          if (!ev && r[(mLast + k) % 4]) begin
            ev = 1'b1;
            pick = (mLast + k) % 4;
          end
        end
      end
      if (ev) begin
        mLast = pick;
        eg = 4'b0001 << pick;
      end
    end
  endtask

  task automatic stepCheck(input string tag, input logic [3:0] r);
    logic [3:0] eg;
    logic ev;
    req = r;
    tick();
    modelStep(r, eg, ev);
    check(tag, {27'd0, gntValid, gnt}, {27'd0, ev, eg});
  endtask

  task automatic writeCtrl(input bit en, input bit load, input logic [2:0] scheme);
    req = '0;
    cfgSel = 1'b1;
    cfgWrData = '0;
    cfgWrData[7] = en;
    cfgWrData[4] = load;
    cfgWrData[2:0] = scheme;
    cfgWrEn = 1'b1;
    tick();
    cfgWrEn = 1'b0;
    mEn = en;
    mWrr = (scheme == 3'b011);
    if (load) begin
      for (int i = 0; i < 128; i++) mTbl[i] = mShadow[i];
      mPtr = 0;
      tick();  // copy lands at the end of this idle cycle
    end
  endtask

  task automatic readCfg(input logic sel, output logic [31:0] val);
    cfgSel = sel;
    #0.5;
    val = cfgRdData;
  endtask

  task automatic tblWrite(input int addr, input logic [1:0] port);
    tblWrEn = 1'b1;
    tblWrAddr = 7'(addr);
    tblWrData = port;
    tick();
    tblWrEn = 1'b0;
    mShadow[addr] = port;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 128; i++) begin
      mTbl[i] = 2'(i % 4);
      mShadow[i] = 2'(i % 4);
    end
    repeat (3) @(negedge clk);
    // R1 reset state of grant outputs
    check("R1 reset gnt", {27'd0, gntValid, gnt}, 32'd0);
    readCfg(1'b0, rd);
    check("R4 capability word", rd, 32'h0000_0009);
    readCfg(1'b1, rd);
    check("R5 R3 control reset", rd, 32'h0000_0080);
    rstN = 1'b1;
    tick();

    // R2 round-robin walk from the vector table
    for (int v = 0; v < 10; v++) begin
      logic [3:0] eg;
      logic ev;
      req = RR_VEC[v][8:5];
      tick();
      modelStep(RR_VEC[v][8:5], eg, ev);
      check("R2 round-robin vector", {27'd0, gntValid, gnt}, {27'd0, RR_VEC[v][0], RR_VEC[v][4:1]});
    end
    req = '0;

    // R4 a write with the capability select changes nothing
    cfgSel = 1'b0; cfgWrData = 32'h0000_0003; cfgWrEn = 1'b1;
    tick();
    cfgWrEn = 1'b0;
    readCfg(1'b1, rd);
    check("R4 capability write ignored", rd, 32'h0000_0080);

    // R3 illegal scheme falls back to round-robin
    writeCtrl(1'b1, 1'b0, 3'b101);
    readCfg(1'b1, rd);
    check("R3 illegal scheme reads 000", rd, 32'h0000_0080);
    stepCheck("R3 fallback acts round-robin", 4'b1111);
    stepCheck("R3 fallback acts round-robin", 4'b1111);

    writeCtrl(1'b1, 1'b0, 3'b011);
    readCfg(1'b1, rd);
    check("R3 weighted code kept", rd, 32'h0000_0083);

    // R8 reset table contents: slot i names port i mod 4
    for (int n = 0; n < 4; n++) stepCheck("R8 reset table order", 4'b1111);

    // R8 shadow writes leave the active table alone
    tblWrite(0, 2'd1);
    tblWrite(1, 2'd3);
    for (int i = 2; i < 128; i++) tblWrite(i, 2'd2);
    for (int n = 0; n < 3; n++) stepCheck("R8 active table undisturbed", 4'b1111);

    // R9 load copies the table and restarts the pointer
    writeCtrl(1'b1, 1'b1, 3'b011);
    readCfg(1'b1, rd);
    check("R9 load bit reads zero", rd, 32'h0000_0083);

    // R6 walk past slot 127 so the pointer wraps
    for (int n = 0; n < 130; n++) stepCheck("R6 weighted walk with wrap", 4'b1111);

    // R7 skipped slots and an unnamed requester
    for (int n = 0; n < 6; n++) stepCheck("R7 skip idle slots", 4'b1011);
    for (int n = 0; n < 3; n++) stepCheck("R7 no slot names requester", 4'b0001);
    stepCheck("R7 pointer held after no grant", 4'b1111);

    // R9 load mid-walk restarts at slot 0
    for (int n = 0; n < 5; n++) stepCheck("R6 weighted walk", 4'b1111);
    writeCtrl(1'b1, 1'b1, 3'b011);
    stepCheck("R9 pointer back at slot 0", 4'b1111);
    stepCheck("R9 pointer back at slot 0", 4'b1111);

    // R5 channel disabled blocks grants
    writeCtrl(1'b0, 1'b0, 3'b011);
    readCfg(1'b1, rd);
    check("R5 enable cleared", rd, 32'h0000_0003);
    for (int n = 0; n < 3; n++) stepCheck("R5 no grant while disabled", 4'b1111);
    writeCtrl(1'b0, 1'b0, 3'b000);
    stepCheck("R5 no grant while disabled", 4'b0110);

    // R2 back to round-robin, last port carried over from weighted grants
    writeCtrl(1'b1, 1'b0, 3'b000);
    for (int n = 0; n < 5; n++) stepCheck("R2 round-robin after weighted", 4'b1111);
    stepCheck("R1 no request no grant", 4'b0000);
    req = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule